// File: doc/BRIEF.md
# Dual-Channel DRAM Rank Decoder

This block turns a physical address, given as its index in 32 MiB units, into the rank that holds it. Software first programs the memory layout through a byte-wide write port. Each of the two channels has four ranks. Each rank has a cumulative 8-bit upper boundary and a 3-bit page-size code. The decoder compares the two channels to decide how they are arranged. If both channels are populated the same way, it treats them as interleaved: only channel 0 is decoded, and every boundary counts double. If they differ, it treats them as one eight-rank sequence: channel 0 ranks come first, followed by channel 1 ranks.

A lookup is presented with `req_valid`. One cycle later the block returns the chosen rank, a hit flag and the interleave flag. A rank takes part in decode only if it is populated. That means its boundary differs from the one below it and its page-size code is one of the three legal sizes.

Top module: `dram_rank_decoder`

## Requirements
- R1: Register writes happen when `cfg_we` is high. Addresses 0 to 3 set the channel 0 boundaries of ranks 0 to 3, and addresses 4 to 7 set the channel 1 boundaries. Addresses 8 and 9 set the channel 0 code bytes, for ranks 0/1 and ranks 2/3. Addresses 10 and 11 set the channel 1 code bytes in the same way. In each code byte, bits 2:0 hold the even rank and bits 6:4 hold the odd rank. A write to address 12 to 15 changes nothing.
- R2: After reset, every boundary and code is 0, and `o_valid`, `o_hit`, `o_rank` and `o_ilv` are 0.
- R3: A request made in cycle N is answered in cycle N+1 with `o_valid` high. The answer uses the register contents as they stood before any write in cycle N. In any cycle without a request answer, `o_valid`, `o_hit`, `o_rank` and `o_ilv` are 0.
- R4: The channels are interleaved exactly when all four boundaries and all four codes of channel 0 equal those of channel 1. Bits 7 and 3 of a code byte are not stored and do not affect this comparison.
- R5: In interleaved mode, only ranks 0 to 3 can be selected. Rank i uses twice the channel 0 boundary i as its effective boundary, and the channel 0 code i.
- R6: In non-interleaved mode, ranks 0 to 7 are decoded in one sequence with boundaries taken as written. Ranks 4 to 7 are channel 1 ranks 0 to 3. The lower neighbour of rank 4 is channel 0 rank 3.
- R7: The selected rank is the lowest-numbered populated rank whose effective boundary is strictly greater than `req_idx`.
- R8: A rank whose effective boundary equals that of the rank below it is empty and is never selected. Rank 0 is compared against 0.
- R9: A rank whose code is not 2, 3 or 4 (the 4 KB, 8 KB and 16 KB page sizes) is empty and is never selected.
- R10: If no populated rank qualifies, `o_hit` is 0 and `o_rank` is 0.
- R11: With a request answer, `o_ilv` reports the interleave decision that was in force in the request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Lookup request |
| req_idx | input | 9 | Address index in 32 MiB units |
| o_valid | output | 1 | Lookup answer present |
| o_hit | output | 1 | A populated rank holds the address |
| o_rank | output | 3 | Selected rank |
| o_ilv | output | 1 | Channels decoded as interleaved |

## Verification
The decoder is driven with random layouts of several kinds:
- Symmetric layouts, some with junk in the unused code bits, which must stay interleaved.
- Asymmetric layouts, in which channel 1 either continues the channel 0 boundaries or restarts below them.

Lookup indices are drawn mostly one below, at and one above an effective boundary. This separates a strict from a non-strict comparison, a doubled from a raw boundary, and a skipped empty rank from a selected one.

Directed layouts isolate four cases:
- An empty rank found by repeated boundaries.
- An empty rank found by an illegal code.
- A write in the same cycle as a request.
- Writes to unmapped addresses.

// File: rtl/dram_rank_decoder.sv
module dram_rank_decoder #(
  parameter  int BW  = 8,
  parameter  int RPC = 4,
  localparam int NR  = 2 * RPC,
  localparam int IW  = BW + 1,
  localparam int AW  = $clog2(NR + RPC),
  localparam int RW  = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          req_valid,
  input  logic [IW-1:0] req_idx,
  output logic          o_valid,
  output logic          o_hit,
  output logic [RW-1:0] o_rank,
  output logic          o_ilv
);

  logic [BW-1:0] bnd [NR];
  logic [2:0]    att [NR];
  logic [IW-1:0] eff [NR];
  logic [NR-1:0] live, cand;
  logic [3*NR-1:0] att_flat;
  logic          ilv, any;
  logic [RW-1:0] sel;
  logic          unused_bits;

  assign unused_bits = cfg_wdata[7] ^ cfg_wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin
        bnd[i] <= '0;
        att[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NR; i++)
        if (cfg_addr == AW'(i)) bnd[i] <= cfg_wdata[BW-1:0];
      for (int j = 0; j < RPC; j++)
        if (cfg_addr == AW'(NR + j)) begin
          att[2*j]   <= cfg_wdata[2:0];
          att[2*j+1] <= cfg_wdata[6:4];
        end
    end
  end

  always_comb begin
    ilv = 1'b1;
    for (int i = 0; i < RPC; i++)
      if (bnd[i] != bnd[i+RPC] || att[i] != att[i+RPC]) ilv = 1'b0;
  end

  for (genvar g = 0; g < NR; g++) begin : g_rank
    logic [IW-1:0] lower;
    assign eff[g] = ilv ? {bnd[g], 1'b0} : {1'b0, bnd[g]};
    if (g == 0) begin : g_first
      assign lower = '0;
    end else begin : g_next
      assign lower = eff[g-1];
    end
    assign live[g] = (!ilv || (g < RPC)) && (eff[g] != lower)
                     && (att[g] inside {3'd2, 3'd3, 3'd4});
    assign cand[g] = live[g] && (eff[g] > req_idx);
    assign att_flat[3*g +: 3] = att[g];
  end

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NR - 1; i >= 0; i--)
      if (cand[i]) begin
        sel = RW'(i);
        any = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_hit   <= 1'b0;
      o_rank  <= '0;
      o_ilv   <= 1'b0;
    end else begin
      o_valid <= req_valid;
      o_hit   <= req_valid && any;
      o_rank  <= (req_valid && any) ? sel : '0;
      o_ilv   <= req_valid && ilv;
    end
  end

endmodule

// File: rtl/dram_rank_decoder_chk.sv
module dram_rank_decoder_chk #(
  parameter  int RPC = 4,
  localparam int NR  = 2 * RPC,
  localparam int RW  = $clog2(NR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            o_valid,
  input logic            o_hit,
  input logic [RW-1:0]   o_rank,
  input logic            o_ilv,
  input logic [3*NR-1:0] att_flat
);

  logic [3*NR-1:0] att_d;
  logic [2:0]      hit_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) att_d <= '0;
    else        att_d <= att_flat;

  assign hit_code = att_d[3*o_rank +: 3];

  a_r3_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> o_valid);
  a_r3_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !o_valid);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> (!o_hit && !o_ilv && o_rank == '0));
  a_r5_ilv_low_ranks: assert property (@(posedge clk) disable iff (!rst_n)
    (o_hit && o_ilv) |-> (o_rank < RW'(RPC)));
  a_r9_hit_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    o_hit |-> (hit_code inside {3'd2, 3'd3, 3'd4}));
  a_r10_miss_rank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_hit) |-> (o_rank == '0));

endmodule

bind dram_rank_decoder dram_rank_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .o_valid(o_valid),
  .o_hit(o_hit), .o_rank(o_rank), .o_ilv(o_ilv), .att_flat(att_flat)
);

// File: tb/tb_dram_rank_decoder.sv
module tb_dram_rank_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       req_valid = 1'b0;
  logic [8:0] req_idx = '0;
  logic       o_valid, o_hit, o_ilv;
  logic [2:0] o_rank;

  always #10 clk = ~clk;

  dram_rank_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_idx(req_idx),
    .o_valid(o_valid), .o_hit(o_hit), .o_rank(o_rank), .o_ilv(o_ilv)
  );

  int n_vec = 0, n_bad = 0;
  int mb [8];
  int ma [8];
  bit done = 0;

  function automatic bit m_ilv();
    for (int i = 0; i < 4; i++)
      if (mb[i] != mb[i+4] || ma[i] != ma[i+4]) return 0;
    return 1;
  endfunction

  function automatic void model(input int idx, output bit hit, output int rank, output bit il);
    int prev, e, n;
    il = m_ilv();
    n = il ? 4 : 8;
    prev = 0; hit = 0; rank = 0;
    for (int i = 0; i < n; i++) begin
      e = il ? 2 * mb[i] : mb[i];
      if (!hit && e != prev && ma[i] >= 2 && ma[i] <= 4 && e > idx) begin
        hit = 1; rank = i;
      end
      prev = e;
    end
  endfunction

  function automatic void apply_wr(int a, logic [7:0] d);
    if (a < 8) mb[a] = d;
    else if (a < 12) begin
      ma[2*(a-8)]   = d[2:0];
      ma[2*(a-8)+1] = d[6:4];
    end
  endfunction

  task automatic check(string tag, bit ev, bit eh, int er, bit ei);
    n_vec++;
    if (o_valid !== ev || o_hit !== eh || o_rank !== er[2:0] || o_ilv !== ei) begin
      n_bad++;
      $display("FAIL %s: got v=%0b h=%0b r=%0d i=%0b, want v=%0b h=%0b r=%0d i=%0b",
               tag, o_valid, o_hit, o_rank, o_ilv, ev, eh, er, ei);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    cfg_we = 1; cfg_addr = a[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    apply_wr(a, d);
  endtask

  task automatic look(string tag, int idx);
    bit h, il; int r;
    model(idx, h, r, il);
    req_valid = 1; req_idx = idx[8:0];
    @(negedge clk);
    req_valid = 0;
    check(tag, 1, h, r, il);
  endtask

  task automatic look_exp(string tag, int idx, bit eh, int er, bit ei);
    req_valid = 1; req_idx = idx[8:0];
    @(negedge clk);
    req_valid = 0;
    check(tag, 1, eh, er, ei);
  endtask

  task automatic load(int b0, int b1, int b2, int b3, int b4, int b5, int b6, int b7,
                      int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
    wr(0, b0[7:0]); wr(1, b1[7:0]); wr(2, b2[7:0]); wr(3, b3[7:0]);
    wr(4, b4[7:0]); wr(5, b5[7:0]); wr(6, b6[7:0]); wr(7, b7[7:0]);
    wr(8,  {1'b0, a1[2:0], 1'b0, a0[2:0]});
    wr(9,  {1'b0, a3[2:0], 1'b0, a2[2:0]});
    wr(10, {1'b0, a5[2:0], 1'b0, a4[2:0]});
    wr(11, {1'b0, a7[2:0], 1'b0, a6[2:0]});
  endtask

  function automatic int pick_code();
    return ($urandom % 4 != 0) ? 2 + int'($urandom % 3) : int'($urandom % 8);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin mb[i] = 0; ma[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R2 reset outputs", 0, 0, 0, 0);
    look_exp("R2/R10 empty layout misses", 5, 0, 0, 1);
    @(negedge clk);
    check("R3 idle after answer", 0, 0, 0, 0);

    load(1, 2, 3, 4, 1, 2, 3, 4, 2, 2, 2, 2, 2, 2, 2, 2);
    look_exp("R5/R11 doubled bound", 7, 1, 3, 1);
    look_exp("R5/R10 at last doubled bound", 8, 0, 0, 1);
    look_exp("R5 rank0", 1, 1, 0, 1);
    look_exp("R7 strict compare", 2, 1, 1, 1);
    wr(8, 8'b1010_1010);
    look_exp("R4 reserved bits ignored", 2, 1, 1, 1);
    wr(10, {1'b0, 3'd2, 1'b0, 3'd3});
    look_exp("R4/R6 code mismatch breaks interleave", 3, 1, 3, 0);
    look_exp("R6 raw bound miss", 4, 0, 0, 0);

    load(4, 4, 4, 4, 8, 9, 9, 20, 2, 2, 2, 2, 2, 2, 2, 2);
    look_exp("R6 rank0", 0, 1, 0, 0);
    look_exp("R6 rank4 above ch0", 4, 1, 4, 0);
    look_exp("R6 rank5", 8, 1, 5, 0);
    look_exp("R8 equal bound skipped", 9, 1, 7, 0);
    look_exp("R10 beyond last", 20, 0, 0, 0);

    load(10, 10, 20, 30, 0, 0, 0, 0, 2, 2, 2, 2, 2, 2, 2, 2);
    look_exp("R8 empty rank1", 12, 1, 2, 0);
    look_exp("R8 rank0", 9, 1, 0, 0);

    load(10, 20, 30, 40, 50, 60, 70, 80, 1, 2, 0, 5, 2, 2, 2, 2);
    look_exp("R9 reserved code skipped", 5, 1, 1, 0);
    look_exp("R9 unpopulated code skipped", 25, 1, 4, 0);
    for (int a = 12; a < 16; a++) wr(a, 8'($urandom));
    look_exp("R1 unmapped write ignored", 5, 1, 1, 0);
    look_exp("R1 unmapped write ignored hi", 25, 1, 4, 0);

    cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = {1'b0, 3'd2, 1'b0, 3'd2};
    req_valid = 1; req_idx = 9'd5;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    apply_wr(8, {1'b0, 3'd2, 1'b0, 3'd2});
    check("R3 write same cycle uses old", 1, 1, 1, 0);
    look_exp("R3 write visible next", 5, 1, 0, 0);

    for (int c = 0; c < 80; c++) begin
      int acc, sym;
      sym = $urandom % 2;
      acc = 0;
      for (int i = 0; i < 4; i++) begin
        if ($urandom % 4 != 0) acc += $urandom % 30;
        wr(i, acc[7:0]);
      end
      if ($urandom % 2 == 0) acc = 0;
      for (int i = 4; i < 8; i++) begin
        if (sym != 0) wr(i, mb[i-4][7:0]);
        else begin
          if ($urandom % 4 != 0) acc += $urandom % 30;
          wr(i, acc[7:0]);
        end
      end
      for (int j = 0; j < 2; j++) begin
        int e0, e1;
        e0 = pick_code(); e1 = pick_code();
        wr(8 + j, {1'($urandom), e1[2:0], 1'($urandom), e0[2:0]});
        if (sym != 0) wr(10 + j, {1'($urandom), e1[2:0], 1'($urandom), e0[2:0]});
        else wr(10 + j, {1'b0, 3'(pick_code()), 1'b0, 3'(pick_code())});
      end
      for (int k = 0; k < 20; k++) begin
        int idx, r, e;
        if ($urandom % 4 == 0) idx = $urandom % 512;
        else begin
          r = $urandom % 8;
          e = m_ilv() ? 2 * mb[r] : mb[r];
          idx = e + int'($urandom % 3) - 1;
          if (idx < 0) idx = 0;
        end
        look("R7/R4/R5/R6 random layout", idx);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule